// File: doc/BRIEF.md
# Modem handshake register with loopback

This block holds an 8-bit handshake output byte, written by a local controller, and turns it into modem control lines for the external line. It also assembles an 8-bit handshake input byte that the controller can read back. A static configuration input selects loopback. In loopback, the output bits feed the modem status inputs of a two-channel serial controller instead of the line, and the external status inputs are cut off from the controller.

The block also steers serial data. Channel A transmit data always reaches channel B receive. It goes to the line transmit pin in normal operation and back into channel A receive in loopback. While the serial reset line is high, the effective output byte reads as all ones, so every control output goes to its inactive-high level with no clock edge in between.

Top module: `hs_loop_top`

## Requirements
- R1: After `rstN` is released, the stored byte is 0x00. With loopback on and serial reset low, `hsReadback` reads 0xC1.
- R2: A write with `hsWrEn` high loads `hsWrData` at the next rising clock edge. While `hsWrEn` is low, the stored byte keeps its value whatever `hsWrData` holds.
- R3: While `serialReset` is high, the effective output byte is 0xFF. This acts in the same cycle and needs no clock edge. When `serialReset` falls, the effective byte returns to the stored byte.
- R4: With loopback off, `lineDtr` equals effective bit 5 and `lineRts` equals effective bit 4. Effective bits 3 to 0 reach no output.
- R5: With loopback on, `chACts` equals effective bit 4, `chADcd` bit 3, `chBCts` bit 2 and `chBDcd` bit 1. `lineDtr` and `lineRts` are held low.
- R6: Readback bits 7, 6 and 0 always read 1.
- R7: With loopback on, readback bits 5 to 1 equal effective bits 5 to 1.
- R8: With loopback off, the readback bits are: bit 5 = `lineRi`, bit 4 = `lineCts`, bit 3 = `lineDcd`, bit 2 = 1, bit 1 = `lineDsr`.
- R9: `chBRxd` always equals `chATxd`. With loopback off, `lineTxd` equals `chATxd`. With loopback on, `chARxd` equals `chATxd` and `lineTxd` is held at 1.
- R10: With loopback off, `chARxd` = `lineRxd`, `chADcd` = `lineDcd`, `chBDcd` = `lineDsr`, `chACts` = `lineCts`, and `chBCts` is held at 1. With loopback on, `lineRxd`, `lineRi`, `lineCts`, `lineDcd` and `lineDsr` affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears the stored byte |
| loopEn | input | 1 | Static loopback selection |
| serialReset | input | 1 | Serial reset; forces the effective byte to all ones |
| hsWrEn | input | 1 | Write strobe for the handshake byte |
| hsWrData | input | 8 | Handshake byte to store |
| hsReadback | output | 8 | Assembled handshake input byte |
| chATxd | input | 1 | Channel A transmit data from the controller |
| chARxd | output | 1 | Channel A receive data to the controller |
| chBRxd | output | 1 | Channel B receive data to the controller |
| chACts | output | 1 | Channel A clear-to-send to the controller |
| chADcd | output | 1 | Channel A carrier detect to the controller |
| chBCts | output | 1 | Channel B clear-to-send to the controller |
| chBDcd | output | 1 | Channel B carrier detect to the controller |
| lineRxd | input | 1 | External receive data |
| lineRi | input | 1 | External ring indicator |
| lineCts | input | 1 | External clear-to-send |
| lineDcd | input | 1 | External carrier detect |
| lineDsr | input | 1 | External data-set-ready |
| lineTxd | output | 1 | External transmit data |
| lineDtr | output | 1 | External data-terminal-ready |
| lineRts | output | 1 | External request-to-send |

## Verification
A write is the only registered path. Its result shows at the first rising edge after the strobe, so the bench drives the write on a falling edge, removes it on the next falling edge and samples only after that. Every other result depends only on the current inputs: the serial reset forcing, loopback steering, readback assembly and line inputs all settle in the same cycle. The bench changes those inputs between edges and samples one time unit later, with no clock edge in between. For each loopback mode, the sweep writes all 256 byte values and then steps through every combination of serial reset, the five line inputs and channel A transmit data.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int HS_W       = 8;
  localparam int BIT_DTR    = 5;
  localparam int BIT_RTS    = 4;
  localparam int BIT_ACTS   = 4;
  localparam int BIT_ADCD   = 3;
  localparam int BIT_BCTS   = 2;
  localparam int BIT_BDCD   = 1;
  localparam int ECHO_LO    = 1;
  localparam int ECHO_HI    = 5;
  localparam logic [HS_W-1:0] READ_BASE = 8'hC1;

  typedef struct packed {
    logic            load;
    logic            force1;
    logic [HS_W-1:0] data;
  } hsStrobe_t;
endpackage

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_pkg::*;
(
  input  logic            wrEn,
  input  logic [HS_W-1:0] wrData,
  input  logic            serialReset,
  output hsStrobe_t       strobe
);
  always_comb begin
    strobe.load   = wrEn;
    strobe.force1 = serialReset;
    strobe.data   = wrData;
  end
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  hsStrobe_t       strobe,
  input  logic            loopEn,
  input  logic            lineRi,
  input  logic            lineCts,
  input  logic            lineDcd,
  input  logic            lineDsr,
  output logic [HS_W-1:0] effective,
  output logic [HS_W-1:0] readback
);
  logic [HS_W-1:0] regQ;
  logic [ECHO_HI:ECHO_LO] extBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regQ <= '0;
    else if (strobe.load)  regQ <= strobe.data;
  end

  assign effective = strobe.force1 ? '1 : regQ;

  // external status arranged on the echo positions; bit 2 is tied high
  assign extBits = {lineRi, lineCts, lineDcd, 1'b1, lineDsr};

  genvar gi;
  generate
    for (gi = 0; gi < HS_W; gi++) begin : g_rb
      if (gi >= ECHO_LO && gi <= ECHO_HI) begin : g_sel
        assign readback[gi] = loopEn ? effective[gi] : extBits[gi];
      end else begin : g_const
        assign readback[gi] = READ_BASE[gi];
      end
    end
  endgenerate

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.force1 |=> (effective == $past(strobe.data)) || strobe.force1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(regQ));
endmodule

// File: rtl/hs_steer.sv
module hs_steer
  import hs_pkg::*;
(
  input  logic                   loopEn,
  input  logic [ECHO_HI:ECHO_LO] eff,
  input  logic                   chATxd,
  input  logic                   lineRxd,
  input  logic                   lineCts,
  input  logic                   lineDcd,
  input  logic                   lineDsr,
  output logic                   chARxd,
  output logic                   chBRxd,
  output logic                   chACts,
  output logic                   chADcd,
  output logic                   chBCts,
  output logic                   chBDcd,
  output logic                   lineTxd,
  output logic                   lineDtr,
  output logic                   lineRts
);
  always_comb begin
    chBRxd = chATxd;
    if (loopEn) begin
      chARxd  = chATxd;
      chACts  = eff[BIT_ACTS];
      chADcd  = eff[BIT_ADCD];
      chBCts  = eff[BIT_BCTS];
      chBDcd  = eff[BIT_BDCD];
      lineTxd = 1'b1;
      lineDtr = 1'b0;
      lineRts = 1'b0;
    end else begin
      chARxd  = lineRxd;
      chACts  = lineCts;
      chADcd  = lineDcd;
      chBCts  = 1'b1;
      chBDcd  = lineDsr;
      lineTxd = chATxd;
      lineDtr = eff[BIT_DTR];
      lineRts = eff[BIT_RTS];
    end
  end
endmodule

// File: rtl/hs_loop_top.sv
module hs_loop_top
  import hs_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            loopEn,
  input  logic            serialReset,
  input  logic            hsWrEn,
  input  logic [HS_W-1:0] hsWrData,
  output logic [HS_W-1:0] hsReadback,
  input  logic            chATxd,
  output logic            chARxd,
  output logic            chBRxd,
  output logic            chACts,
  output logic            chADcd,
  output logic            chBCts,
  output logic            chBDcd,
  input  logic            lineRxd,
  input  logic            lineRi,
  input  logic            lineCts,
  input  logic            lineDcd,
  input  logic            lineDsr,
  output logic            lineTxd,
  output logic            lineDtr,
  output logic            lineRts
);
  hsStrobe_t       strobe;
  logic [HS_W-1:0] effective;

  hs_ctrl i_ctrl (
    .wrEn(hsWrEn), .wrData(hsWrData), .serialReset(serialReset), .strobe(strobe)
  );

  hs_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loopEn(loopEn),
    .lineRi(lineRi), .lineCts(lineCts), .lineDcd(lineDcd), .lineDsr(lineDsr),
    .effective(effective), .readback(hsReadback)
  );

  hs_steer i_steer (
    .loopEn(loopEn), .eff(effective[ECHO_HI:ECHO_LO]), .chATxd(chATxd),
    .lineRxd(lineRxd), .lineCts(lineCts), .lineDcd(lineDcd), .lineDsr(lineDsr),
    .chARxd(chARxd), .chBRxd(chBRxd), .chACts(chACts), .chADcd(chADcd),
    .chBCts(chBCts), .chBDcd(chBDcd), .lineTxd(lineTxd), .lineDtr(lineDtr),
    .lineRts(lineRts)
  );

  assert_force_R3: assert property (@(posedge clk) disable iff (!rstN)
    serialReset && !loopEn |-> lineDtr && lineRts);
  assert_echo_R7: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> hsReadback[4] == chACts && hsReadback[3] == chADcd &&
               hsReadback[2] == chBCts && hsReadback[1] == chBDcd);
  assert_loop_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> chARxd == chBRxd && lineTxd);
  assert_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loopEn |-> hsReadback[3] == chADcd && hsReadback[1] == chBDcd && hsReadback[4] == chACts);
endmodule

// File: tb/test_hs_loop_top.sv
`timescale 1ns/1ps
module test_hs_loop_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loopEn = 1'b1, serialReset = 1'b0, hsWrEn = 1'b0;
  logic [7:0] hsWrData = 8'h00;
  logic [7:0] hsReadback;
  logic chATxd = 1'b1;
  logic chARxd, chBRxd, chACts, chADcd, chBCts, chBDcd;
  logic lineRxd = 1'b1, lineRi = 1'b0, lineCts = 1'b0, lineDcd = 1'b0, lineDsr = 1'b0;
  logic lineTxd, lineDtr, lineRts;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_loop_top i_hs_loop_top (
    .clk(clk), .rstN(rstN), .loopEn(loopEn), .serialReset(serialReset),
    .hsWrEn(hsWrEn), .hsWrData(hsWrData), .hsReadback(hsReadback),
    .chATxd(chATxd), .chARxd(chARxd), .chBRxd(chBRxd), .chACts(chACts),
    .chADcd(chADcd), .chBCts(chBCts), .chBDcd(chBDcd),
    .lineRxd(lineRxd), .lineRi(lineRi), .lineCts(lineCts), .lineDcd(lineDcd),
    .lineDsr(lineDsr), .lineTxd(lineTxd), .lineDtr(lineDtr), .lineRts(lineRts)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors <= 20) $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] v);
    @(negedge clk); hsWrEn = 1'b1; hsWrData = v;
    @(negedge clk); hsWrEn = 1'b0; hsWrData = ~v;
  endtask

  // compare every output with values derived from the requirements
  task automatic checkAll(input logic [7:0] stored);
    logic [7:0] eff;
    logic [7:0] expRb;
    logic [2:0] expLine;
    logic [5:0] expCh;
    eff = serialReset ? 8'hFF : stored;
    if (loopEn) begin
      expRb   = 8'hC1 | (eff & 8'h3E);
      expLine = {1'b1, 1'b0, 1'b0};
      expCh   = {chATxd, chATxd, eff[4], eff[3], eff[2], eff[1]};
    end else begin
      expRb   = {2'b11, lineRi, lineCts, lineDcd, 1'b1, lineDsr, 1'b1};
      expLine = {chATxd, eff[5], eff[4]};
      expCh   = {lineRxd, chATxd, lineCts, lineDcd, 1'b1, lineDsr};
    end
    check("R6 const bits", {8'h0, hsReadback & 8'hC1}, 16'h00C1);
    check(loopEn ? "R7 readback echo" : "R8 readback line", {8'h0, hsReadback}, {8'h0, expRb});
    check(loopEn ? "R5 line held" : "R4 dtr/rts", {13'h0, lineTxd, lineDtr, lineRts}, {13'h0, expLine});
    check(loopEn ? "R5/R9 ctrl loop" : "R10 ctrl pass",
          {10'h0, chARxd, chBRxd, chACts, chADcd, chBCts, chBDcd}, {10'h0, expCh});
    if (serialReset && !loopEn) check("R3 forced", {14'h0, lineDtr, lineRts}, 16'h0003);
  endtask

  initial begin
    #50000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset readback", {8'h0, hsReadback}, 16'h00C1);
    // R2 hold while strobe low
    hsWrData = 8'hFF;
    @(negedge clk); @(negedge clk);
    check("R2 hold", {8'h0, hsReadback}, 16'h00C1);
    // R3 same-cycle forcing and release
    serialReset = 1'b1; #1;
    check("R3 force", {8'h0, hsReadback}, 16'h00FF);
    serialReset = 1'b0; #1;
    check("R3 release", {8'h0, hsReadback}, 16'h00C1);
    for (int m = 1; m >= 0; m--) begin
      loopEn = m[0];
      for (int v = 0; v < 256; v++) begin
        writeByte(v[7:0]);
        for (int c = 0; c < 128; c++) begin
          serialReset = c[0];
          chATxd = c[1];
          {lineRxd, lineRi, lineCts, lineDcd, lineDsr} = c[6:2];
          #1;
          checkAll(v[7:0]);
        end
        serialReset = 1'b0;
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule